// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard and Redirect Controller

This block is the hazard control unit for an in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Every cycle it looks at the instruction class and register specifiers held in the decode (ID), execute (EX), memory (MEM) and write-back (WB) stages, and at the branch outcomes reported by ID and EX. From these it decides five things. It decides whether fetch and decode must hold. It decides whether the fetch/decode and decode/execute pipeline registers must be emptied. It picks the source for each of the two EX operands. It picks where the next program counter comes from. All of these decisions are combinational, so each one applies to the clock edge that closes the cycle in which its inputs are presented.

The elaboration-time parameter `POLICY` selects one of three behaviours:

- **Policy 0** has no bypassing. Branches are decided in ID, and a taken branch flushes the instruction fetched behind it.
- **Policy 1** has full bypassing. The branch target is formed in ID, the branch is decided in EX, and fetch continues down the fall-through path until then.
- **Policy 2** has full bypassing, branches decided in EX, and one architectural delay slot that is never discarded.

Memory is single-cycle, so load data exists at the end of MEM. The register file writes in the first half of a cycle and reads in the second half.

Top module: `hazard_ctrl`

## Requirements
- R1: Instruction class codes are NOP=0, ALU=1, LOAD=2, STORE=3, BRANCH=4. Under POLICY 0, both operand selects stay 0. A non-NOP instruction in ID stalls while an ALU or LOAD in EX or MEM has a destination equal to one of its source specifiers. A matching producer in WB causes no stall.
- R2: A stall raises `stall` and `kill_idex` together, so that a bubble enters EX, and leaves `pc_sel` at 0.
- R3: Under POLICY 1 and 2, a stall occurs only when the EX instruction is a LOAD whose destination matches a source of a non-NOP ID instruction. Such a stall lasts one bubble. An ALU producer in EX never stalls.
- R4: Under POLICY 1 and 2, operand select codes are register file=0, MEM-stage result=1, WB-stage result=2. A matching producer in MEM wins over one in WB.
- R5: Register 0 is never a dependency: it neither stalls nor forwards.
- R6: pc_sel codes are sequential=0, ID target=1, EX target=2. Under POLICY 0, a taken BRANCH in ID that is not stalled gives pc_sel=1 and `kill_ifid`. A stalled branch gives no redirect. The EX branch outcome is ignored.
- R7: Under POLICY 1, a taken BRANCH in EX gives pc_sel=2 and raises both `kill_ifid` and `kill_idex`. The ID branch outcome is ignored.
- R8: Under POLICY 2, a taken BRANCH in EX gives pc_sel=2 and raises `kill_ifid` only. The delay-slot instruction in ID is never killed.
- R9: A BRANCH whose outcome is not-taken causes no redirect and no kill under any policy.
- R10: While `rst` is high, every output is 0.
- R11: STORE, BRANCH and NOP never act as producers, so a destination field in those classes neither stalls nor forwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the embedded checks) |
| rst | input | 1 | Synchronous active-high reset; quiets all outputs |
| id_cls | input | 3 | Class of the instruction in ID |
| id_rs1 | input | 5 | First source specifier in ID (0 if unused) |
| id_rs2 | input | 5 | Second source specifier in ID (0 if unused) |
| id_br_taken | input | 1 | Branch outcome computed in ID |
| ex_cls | input | 3 | Class of the instruction in EX |
| ex_rs1 | input | 5 | First source specifier in EX |
| ex_rs2 | input | 5 | Second source specifier in EX |
| ex_rd | input | 5 | Destination specifier in EX |
| ex_br_taken | input | 1 | Branch outcome computed in EX |
| mem_cls | input | 3 | Class of the instruction in MEM |
| mem_rd | input | 5 | Destination specifier in MEM |
| wb_cls | input | 3 | Class of the instruction in WB |
| wb_rd | input | 5 | Destination specifier in WB |
| stall | output | 1 | Hold PC and the fetch/decode register |
| kill_ifid | output | 1 | Load a bubble into the fetch/decode register |
| kill_idex | output | 1 | Load a bubble into the decode/execute register |
| fwd_a | output | 2 | Source select for EX operand A |
| fwd_b | output | 2 | Source select for EX operand B |
| pc_sel | output | 2 | Next-PC source select |

## Verification
Every output is a combinational function of the stage contents, so its value is due in the same cycle that those contents are presented. That value governs the edge that ends the cycle.

The bench changes the stage contents on the falling edge and reads the outputs a few nanoseconds later, well before the next rising edge. Three copies of the unit, one per policy, receive identical stage contents. Each copy's result is compared against the expected value for its policy, so one scenario shows how the policies differ. The reset check applies a load-use pattern while reset is held, which proves that the gating overrides a live hazard.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    localparam int REG_W = 5;
    localparam int CLS_W = 3;
    localparam int SEL_W = 2;

    localparam int POL_NOFWD = 0;
    localparam int POL_FWD   = 1;
    localparam int POL_DSLOT = 2;

    typedef enum logic [CLS_W-1:0] {
        CL_NOP    = 3'd0,
        CL_ALU    = 3'd1,
        CL_LOAD   = 3'd2,
        CL_STORE  = 3'd3,
        CL_BRANCH = 3'd4
    } iclass_e;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } opnd_src_e;

    typedef enum logic [SEL_W-1:0] {
        NPC_SEQ = 2'd0,
        NPC_ID  = 2'd1,
        NPC_EX  = 2'd2
    } npc_e;

    // A stage's contribution as a possible register producer
    typedef struct packed {
        logic             wr;
        logic [REG_W-1:0] rd;
    } prod_t;

    function automatic logic writes_reg(iclass_e c);
        return (c == CL_ALU) || (c == CL_LOAD);
    endfunction

    function automatic prod_t make_prod(iclass_e c, logic [REG_W-1:0] rd);
        prod_t p;
        p.wr = writes_reg(c) && (rd != '0);
        p.rd = rd;
        return p;
    endfunction

    function automatic logic depends_on(prod_t p, logic [REG_W-1:0] src);
        return p.wr && (src != '0) && (p.rd == src);
    endfunction

endpackage

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
    import hazard_pkg::*;
#(
    parameter int POLICY = POL_FWD
) (
    input  iclass_e          id_cls,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  iclass_e          ex_cls,
    input  prod_t            ex_p,
    input  prod_t            mem_p,
    output logic             need_stall
);
    localparam bit NO_BYPASS = (POLICY == POL_NOFWD);

    logic id_live, ex_hit, mem_hit;

    always_comb begin
        id_live = (id_cls != CL_NOP);
        ex_hit  = depends_on(ex_p, id_rs1) || depends_on(ex_p, id_rs2);
        mem_hit = depends_on(mem_p, id_rs1) || depends_on(mem_p, id_rs2);
        if (NO_BYPASS) begin
            // value becomes readable only once its producer is in WB
            need_stall = id_live && (ex_hit || mem_hit);
        end else begin
            // only a load result is too late for the EX bypass
            need_stall = id_live && ex_hit && (ex_cls == CL_LOAD);
        end
    end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hazard_pkg::*;
#(
    parameter int POLICY = POL_FWD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] src,
    input  prod_t            mem_p,
    input  prod_t            wb_p,
    output opnd_src_e        sel
);
    localparam bit BYPASS_ON = (POLICY != POL_NOFWD);

    always_comb begin
        sel = SRC_RF;
        if (BYPASS_ON) begin
            if (depends_on(mem_p, src))      sel = SRC_MEM;
            else if (depends_on(wb_p, src))  sel = SRC_WB;
        end
    end

    // R5
    r0_never_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> (sel == SRC_RF));

    // R4
    mem_fwd_match_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_MEM) |-> (mem_p.wr && mem_p.rd == src));

endmodule

// File: rtl/hz_redirect.sv
module hz_redirect
    import hazard_pkg::*;
#(
    parameter int POLICY = POL_FWD
) (
    input  iclass_e id_cls,
    input  logic    id_taken,
    input  logic    id_stalled,
    input  iclass_e ex_cls,
    input  logic    ex_taken,
    output npc_e    npc,
    output logic    kill_if,
    output logic    kill_id
);
    logic id_go, ex_go;

    always_comb begin
        id_go   = (id_cls == CL_BRANCH) && id_taken && !id_stalled;
        ex_go   = (ex_cls == CL_BRANCH) && ex_taken;
        npc     = NPC_SEQ;
        kill_if = 1'b0;
        kill_id = 1'b0;
        case (POLICY)
            POL_NOFWD: if (id_go) begin
                npc     = NPC_ID;
                kill_if = 1'b1;
            end
            POL_DSLOT: if (ex_go) begin
                npc     = NPC_EX;
                kill_if = 1'b1;
            end
            default: if (ex_go) begin
                npc     = NPC_EX;
                kill_if = 1'b1;
                kill_id = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hazard_pkg::*;
#(
    parameter int POLICY = POL_FWD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CLS_W-1:0] id_cls,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_br_taken,
    input  logic [CLS_W-1:0] ex_cls,
    input  logic [REG_W-1:0] ex_rs1,
    input  logic [REG_W-1:0] ex_rs2,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_br_taken,
    input  logic [CLS_W-1:0] mem_cls,
    input  logic [REG_W-1:0] mem_rd,
    input  logic [CLS_W-1:0] wb_cls,
    input  logic [REG_W-1:0] wb_rd,
    output logic             stall,
    output logic             kill_ifid,
    output logic             kill_idex,
    output logic [SEL_W-1:0] fwd_a,
    output logic [SEL_W-1:0] fwd_b,
    output logic [SEL_W-1:0] pc_sel
);
    localparam int N_OPND = 2;

    iclass_e id_c, ex_c, mem_c, wb_c;
    prod_t   ex_p, mem_p, wb_p;
    logic    raw_stall, br_kill_if, br_kill_id;
    npc_e    npc;

    logic      [REG_W-1:0] ex_src [N_OPND];
    opnd_src_e             pick   [N_OPND];

    always_comb begin
        id_c  = iclass_e'(id_cls);
        ex_c  = iclass_e'(ex_cls);
        mem_c = iclass_e'(mem_cls);
        wb_c  = iclass_e'(wb_cls);
        ex_p  = make_prod(ex_c, ex_rd);
        mem_p = make_prod(mem_c, mem_rd);
        wb_p  = make_prod(wb_c, wb_rd);
        ex_src[0] = ex_rs1;
        ex_src[1] = ex_rs2;
    end

    hz_stall_detect #(.POLICY(POLICY)) u_stall (
        .id_cls     (id_c),
        .id_rs1     (id_rs1),
        .id_rs2     (id_rs2),
        .ex_cls     (ex_c),
        .ex_p       (ex_p),
        .mem_p      (mem_p),
        .need_stall (raw_stall)
    );

    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
        hz_fwd_pick #(.POLICY(POLICY)) u_pick (
            .clk   (clk),
            .rst   (rst),
            .src   (ex_src[k]),
            .mem_p (mem_p),
            .wb_p  (wb_p),
            .sel   (pick[k])
        );
    end

    hz_redirect #(.POLICY(POLICY)) u_redir (
        .id_cls     (id_c),
        .id_taken   (id_br_taken),
        .id_stalled (raw_stall),
        .ex_cls     (ex_c),
        .ex_taken   (ex_br_taken),
        .npc        (npc),
        .kill_if    (br_kill_if),
        .kill_id    (br_kill_id)
    );

    // a flush of the ID instruction overrides any stall it requested
    always_comb begin
        stall     = !rst && raw_stall && !br_kill_id;
        kill_ifid = !rst && br_kill_if;
        kill_idex = !rst && (br_kill_id || stall);
        pc_sel    = rst ? NPC_SEQ : npc;
        fwd_a     = rst ? SRC_RF : pick[0];
        fwd_b     = rst ? SRC_RF : pick[1];
    end

    // R3
    load_use_only_chk: assert property (@(posedge clk) disable iff (rst)
        (POLICY != POL_NOFWD && stall) |-> (ex_cls == CL_LOAD));

    // R8
    slot_survives_chk: assert property (@(posedge clk) disable iff (rst)
        (POLICY == POL_DSLOT && kill_idex) |-> stall);

    // R6
    id_redirect_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_sel == NPC_ID) |-> (!stall && kill_ifid && id_cls == CL_BRANCH));

    // R2
    bubble_with_stall_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (kill_idex && pc_sel == NPC_SEQ));

endmodule

// File: tb/hazard_ctrl_test.sv
module hazard_ctrl_test;
    localparam logic [2:0] N = 3'd0, A = 3'd1, L = 3'd2, S = 3'd3, B = 3'd4;
    localparam int NV = 17;

    typedef struct packed {
        logic [2:0] ic; logic [4:0] i1; logic [4:0] i2; logic it;
        logic [2:0] ec; logic [4:0] e1; logic [4:0] e2; logic [4:0] ed; logic et;
        logic [2:0] mc; logic [4:0] md;
        logic [2:0] wc; logic [4:0] wd;
        logic [8:0] x0; logic [8:0] x1; logic [8:0] x2;
        logic [3:0] rq;
    } vec_t;

    // expected = {stall, kill_ifid, kill_idex, fwd_a, fwd_b, pc_sel} per policy 0/1/2
    localparam vec_t VEC [NV] = '{
        '{N,0,0,0, N,0,0,0,0, N,0, N,0, 9'b000000000, 9'b000000000, 9'b000000000, 4'd4},  // R4 idle
        '{N,0,0,0, A,3,4,5,0, A,3, A,4, 9'b000000000, 9'b000011000, 9'b000011000, 4'd4},  // R4 mem+wb
        '{N,0,0,0, A,3,3,5,0, A,3, A,3, 9'b000000000, 9'b000010100, 9'b000010100, 4'd4},  // R4 priority
        '{N,0,0,0, A,0,0,5,0, A,0, A,0, 9'b000000000, 9'b000000000, 9'b000000000, 4'd5},  // R5
        '{N,0,0,0, A,3,0,5,0, S,3, L,3, 9'b000000000, 9'b000100000, 9'b000100000, 4'd11}, // R11
        '{A,6,7,0, L,2,0,6,0, N,0, N,0, 9'b101000000, 9'b101000000, 9'b101000000, 4'd3},  // R3 load-use
        '{A,1,6,0, A,0,0,6,0, N,0, N,0, 9'b101000000, 9'b000000000, 9'b000000000, 4'd1},  // R1 EX dep
        '{A,6,0,0, N,0,0,0,0, A,6, N,0, 9'b101000000, 9'b000000000, 9'b000000000, 4'd1},  // R1 MEM dep
        '{A,6,0,0, N,0,0,0,0, N,0, A,6, 9'b000000000, 9'b000000000, 9'b000000000, 4'd1},  // R1 WB dep
        '{B,4,0,1, N,0,0,0,0, N,0, N,0, 9'b010000001, 9'b000000000, 9'b000000000, 4'd6},  // R6 taken
        '{B,4,0,1, A,0,0,4,0, N,0, N,0, 9'b101000000, 9'b000000000, 9'b000000000, 4'd6},  // R6 stalled
        '{A,1,0,0, B,0,0,0,1, N,0, N,0, 9'b000000000, 9'b011000010, 9'b010000010, 4'd7},  // R7 R8
        '{A,1,0,0, B,0,0,0,0, N,0, N,0, 9'b000000000, 9'b000000000, 9'b000000000, 4'd9},  // R9 EX
        '{A,1,0,0, B,5,0,0,1, A,5, N,0, 9'b000000000, 9'b011010010, 9'b010010010, 4'd8},  // R8 fwd
        '{S,0,8,0, L,0,0,8,0, N,0, N,0, 9'b101000000, 9'b101000000, 9'b101000000, 4'd2},  // R2 store
        '{B,4,0,0, N,0,0,0,0, N,0, N,0, 9'b000000000, 9'b000000000, 9'b000000000, 4'd9},  // R9 ID
        '{A,0,0,0, L,0,0,0,0, N,0, N,0, 9'b000000000, 9'b000000000, 9'b000000000, 4'd5}   // R5 load r0
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] id_cls, ex_cls, mem_cls, wb_cls;
    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_br_taken, ex_br_taken;
    logic [8:0] got [3];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    for (genvar p = 0; p < 3; p++) begin : g_pol
        logic st, ki, ke;
        logic [1:0] fa, fb, pc;
        if (p == 0) begin : g_u
            hazard_ctrl #(.POLICY(0)) uut (.clk, .rst, .id_cls, .id_rs1, .id_rs2, .id_br_taken,
                .ex_cls, .ex_rs1, .ex_rs2, .ex_rd, .ex_br_taken, .mem_cls, .mem_rd, .wb_cls, .wb_rd,
                .stall(st), .kill_ifid(ki), .kill_idex(ke), .fwd_a(fa), .fwd_b(fb), .pc_sel(pc));
        end else begin : g_u
            hazard_ctrl #(.POLICY(p)) uut (.clk, .rst, .id_cls, .id_rs1, .id_rs2, .id_br_taken,
                .ex_cls, .ex_rs1, .ex_rs2, .ex_rd, .ex_br_taken, .mem_cls, .mem_rd, .wb_cls, .wb_rd,
                .stall(st), .kill_ifid(ki), .kill_idex(ke), .fwd_a(fa), .fwd_b(fb), .pc_sel(pc));
        end
        assign got[p] = {st, ki, ke, fa, fb, pc};
    end

    task automatic apply(input vec_t v);
        id_cls = v.ic; id_rs1 = v.i1; id_rs2 = v.i2; id_br_taken = v.it;
        ex_cls = v.ec; ex_rs1 = v.e1; ex_rs2 = v.e2; ex_rd = v.ed; ex_br_taken = v.et;
        mem_cls = v.mc; mem_rd = v.md; wb_cls = v.wc; wb_rd = v.wd;
    endtask

    task automatic check(input string tag, input int pol, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s policy %0d: got %b expected %b", tag, pol, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: got cycle %0d expected under 5000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset held over a live load-use and taken-branch pattern
        apply(VEC[5]);
        ex_br_taken = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        for (int p = 0; p < 3; p++) check("R10 reset quiet", p, got[p], 9'b0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            #2;
            check($sformatf("R%0d vector %0d", VEC[i].rq, i), 0, got[0], VEC[i].x0);
            check($sformatf("R%0d vector %0d", VEC[i].rq, i), 1, got[1], VEC[i].x1);
            check($sformatf("R%0d vector %0d", VEC[i].rq, i), 2, got[2], VEC[i].x2);
        end
        // R7: ID branch outcome ignored when decided in EX; R6: EX outcome ignored in policy 0
        @(negedge clk);
        apply(VEC[0]);
        id_cls = B; id_br_taken = 1'b1; ex_cls = B; ex_br_taken = 1'b1;
        #2;
        check("R6 EX outcome ignored", 0, got[0], 9'b010000001);
        check("R7 ID outcome ignored", 1, got[1], 9'b011000010);
        check("R8 slot kept", 2, got[2], 9'b010000010);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule